// File: doc/BRIEF.md
# I2C Message Transfer Sequencer

This block carries out one I2C message in hardware on behalf of a status-coded I2C master core. It takes a message descriptor on a start pulse: target address, read flag, 10-bit flag, reverse-direction flag, no-start flag and byte count. The core reports progress by pulsing an event line together with an 8-bit status code. On each event the sequencer writes a data byte to the core if one is needed (an address byte or the next transmit byte), and it always writes a control word. Transmit bytes come from a byte source that the block acknowledges one byte at a time. Received bytes go out on a one-cycle valid strobe. When the message ends, a done pulse carries a result code.

The next action depends only on the status code, the number of bytes still to move and a pending-abort flag. A programmable cycle timeout runs while the block is busy and restarts at every accepted start or event. When it expires the first time, the block marks the message as aborting and lets it wind down cleanly. When it expires a second time, the block gives up and reports a locked bus. The block has a single message in flight at a time. Messages are chained by starting the next one after done.

Top module: `i2c_msg_seq`

## Requirements
- R1: For a 7-bit address the first address byte is {addr[6:0], dir}. dir is rd XOR rev, so a read gives 1, and the reverse flag inverts it.
- R2: With the 10-bit flag set, the first address byte is 0xF0 | (addr[9:8] << 1) | dir. The second address byte is addr[7:0] and is sent on status 0x18 or 0x40.
- R3: A start pulse while idle (no-start flag clear) writes control word 0x0F. The control bits are bus-enable bit 0, interrupt-enable bit 1, ACK-enable bit 2, start bit 3 and stop bit 4. Status 0x08 or 0x10 then loads the first address byte with control 0x07.
- R4: On status 0x18 (7-bit), 0xD0 or 0x28, the next transmit byte is written with tx_take_o when bytes remain. When none remain, the block issues stop and done with result OK (0).
- R5: On status 0x40 (7-bit) or 0xE0 with bytes requested, the block writes control with no data byte. Status 0x50 outputs the received byte and counts it down. ACK-enable (bit 2) is cleared once exactly one byte remains. Status 0x58 outputs the last byte and stops.
- R6: A zero-length read or write ends at the address acknowledge with stop and result OK.
- R7: Status 0x20, 0x30 or 0x48 ends the message with result NODEV (1). Any status not otherwise listed ends it with result IOERR (2).
- R8: Every stop write sets bit 4, clears interrupt-enable, keeps the current ACK-enable bit and comes with done_o for one cycle. busy_o is low in that same cycle.
- R9: With the no-start flag set, start and address are skipped. A write sends its first byte at once with control 0x07. A read writes control 0x07 and waits for data.
- R10: An event while idle is answered with control word 0x11 and no done.
- R11: After one timeout, a write-path acknowledge stops the message if at least one byte has gone out, and a read clears ACK-enable at once. The done result is then TIMEOUT (3).
- R12: A second timeout with no completion raises done with result LOCKED (4) and no control write. It arrives 2*(limit+1) cycles after the start.
- R13: A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start one message (taken when idle) |
| addr_i | input | 10 | Target address |
| ten_i | input | 1 | 10-bit addressing |
| rd_i | input | 1 | Read message |
| rev_i | input | 1 | Invert direction bit |
| nostart_i | input | 1 | Skip start and address |
| len_i | input | LEN_W | Byte count |
| tmo_limit_i | input | TMO_W | Timeout in cycles (at least 1) |
| tx_data_i | input | 8 | Current transmit byte |
| tx_take_o | output | 1 | Transmit byte consumed |
| rx_valid_o | output | 1 | Received byte strobe |
| rx_data_o | output | 8 | Received byte |
| busy_o | output | 1 | Message in flight |
| done_o | output | 1 | Message finished |
| result_o | output | 3 | Result code |
| evt_i | input | 1 | Core event pulse |
| status_i | input | 8 | Core status code |
| core_rdata_i | input | 8 | Core receive data |
| ctl_we_o | output | 1 | Control write strobe |
| ctl_word_o | output | 8 | Control word |
| dat_we_o | output | 1 | Data write strobe |
| dat_o | output | 8 | Data byte to core |

## Verification
The assertions assume that each core event is a single-cycle pulse that never coincides with a start pulse. They also assume that the core raises 0x50 only while more than one byte remains, and that the timeout limit is at least one. The stimulus keeps to these rules by construction. Every event is driven for exactly one cycle by a task that never overlaps the start task. Read flows issue len-1 data acknowledges before the final 0x58. The limit is held at 1000 for random messages, which is well above any message length, and set small only in the timeout cases.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
   localparam int CW_BUS   = 0;
   localparam int CW_INT   = 1;
   localparam int CW_ACK   = 2;
   localparam int CW_START = 3;
   localparam int CW_STOP  = 4;

   localparam logic [7:0] ST_START   = 8'h08;
   localparam logic [7:0] ST_RSTART  = 8'h10;
   localparam logic [7:0] ST_WA_ACK  = 8'h18;
   localparam logic [7:0] ST_WA_NAK  = 8'h20;
   localparam logic [7:0] ST_WD_ACK  = 8'h28;
   localparam logic [7:0] ST_WD_NAK  = 8'h30;
   localparam logic [7:0] ST_RA_ACK  = 8'h40;
   localparam logic [7:0] ST_RA_NAK  = 8'h48;
   localparam logic [7:0] ST_RD_ACK  = 8'h50;
   localparam logic [7:0] ST_RD_NAK  = 8'h58;
   localparam logic [7:0] ST_WA2_ACK = 8'hD0;
   localparam logic [7:0] ST_RA2_ACK = 8'hE0;

   typedef enum logic [2:0] {RES_OK, RES_NODEV, RES_IOERR, RES_TIMEOUT, RES_LOCKED} result_e;
   typedef enum logic [2:0] {PH_IDLE, PH_START, PH_ADDR1, PH_ADDR2, PH_TXACK, PH_RXDATA} phase_e;
   typedef enum logic [1:0] {SRC_NONE, SRC_ADDR1, SRC_ADDR2, SRC_TX} dsrc_e;

   typedef struct packed {
      dsrc_e   src;
      logic    stop;
      logic    clr_ack;
      logic    take;
      logic    rx;
      logic    dec;
      result_e res;
      phase_e  nxt;
   } step_t;
endpackage

// File: rtl/i2cseq_addr_fmt.sv
module i2cseq_addr_fmt #(
   parameter bit TEN_EN = 1'b1
) (
   input  logic [9:0] addr_i,
   input  logic       ten_i,
   input  logic       rd_i,
   input  logic       rev_i,
   output logic       ten_o,
   output logic [7:0] first_o,
   output logic [7:0] second_o
);
   logic dir;
   assign dir = rd_i ^ rev_i;

   generate
      if (TEN_EN) begin : g_ten
         assign ten_o    = ten_i;
         assign first_o  = ten_i ? {5'b11110, addr_i[9:8], dir} : {addr_i[6:0], dir};
         assign second_o = addr_i[7:0];
      end else begin : g_seven
         logic [2:0] unused_hi;
         assign unused_hi = {addr_i[9:7] & {3{ten_i}}};
         assign ten_o    = 1'b0;
         assign first_o  = {addr_i[6:0], dir};
         assign second_o = {5'd0, unused_hi} & 8'h00;
      end
   endgenerate
endmodule

// File: rtl/i2cseq_wdog.sv
module i2cseq_wdog #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy_i,
   input  logic             restart_i,
   input  logic [TMO_W-1:0] limit_i,
   output logic             expire_o
);
   logic [TMO_W-1:0] cnt_q;

   assign expire_o = busy_i && !restart_i && (cnt_q == limit_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (restart_i)        cnt_q <= '0;
      else if (busy_i) begin
         if (cnt_q == limit_i)   cnt_q <= '0;
         else                    cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/i2cseq_decide.sv
module i2cseq_decide
   import i2cseq_pkg::*;
#(
   parameter int LEN_W = 8
) (
   input  logic [7:0]       status_i,
   input  logic             ten_i,
   input  logic [LEN_W-1:0] left_i,
   input  logic             abort_i,
   input  logic             sent_i,
   output step_t            step_o
);
   logic wr_path, rd_path;

   always_comb begin
      step_o  = '0;
      wr_path = 1'b0;
      rd_path = 1'b0;
      case (status_i)
         ST_START, ST_RSTART: begin
            step_o.src = SRC_ADDR1;
            step_o.nxt = PH_ADDR1;
         end
         ST_WA_ACK: begin
            if (ten_i) begin
               step_o.src = SRC_ADDR2;
               step_o.nxt = PH_ADDR2;
            end else wr_path = 1'b1;
         end
         ST_WA2_ACK, ST_WD_ACK: wr_path = 1'b1;
         ST_RA_ACK: begin
            if (ten_i) begin
               step_o.src = SRC_ADDR2;
               step_o.nxt = PH_ADDR2;
            end else rd_path = 1'b1;
         end
         ST_RA2_ACK: rd_path = 1'b1;
         ST_RD_ACK: begin
            step_o.rx      = 1'b1;
            step_o.dec     = 1'b1;
            step_o.clr_ack = (left_i == LEN_W'(2)) || abort_i;
            step_o.nxt     = PH_RXDATA;
         end
         ST_RD_NAK: begin
            step_o.rx   = 1'b1;
            step_o.stop = 1'b1;
         end
         ST_WA_NAK, ST_WD_NAK, ST_RA_NAK: begin
            step_o.stop = 1'b1;
            step_o.res  = RES_NODEV;
         end
         default: begin
            step_o.stop = 1'b1;
            step_o.res  = RES_IOERR;
         end
      endcase

      if (wr_path) begin
         if ((left_i == '0) || (abort_i && sent_i)) step_o.stop = 1'b1;
         else begin
            step_o.src  = SRC_TX;
            step_o.take = 1'b1;
            step_o.dec  = 1'b1;
            step_o.nxt  = PH_TXACK;
         end
      end
      if (rd_path) begin
         if (left_i == '0) step_o.stop = 1'b1;
         else begin
            step_o.clr_ack = (left_i == LEN_W'(1)) || abort_i;
            step_o.nxt     = PH_RXDATA;
         end
      end
   end
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
   import i2cseq_pkg::*;
#(
   parameter int LEN_W  = 8,
   parameter int TMO_W  = 16,
   parameter bit TEN_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [9:0]       addr_i,
   input  logic             ten_i,
   input  logic             rd_i,
   input  logic             rev_i,
   input  logic             nostart_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic [TMO_W-1:0] tmo_limit_i,
   input  logic [7:0]       tx_data_i,
   output logic             tx_take_o,
   output logic             rx_valid_o,
   output logic [7:0]       rx_data_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [2:0]       result_o,
   input  logic             evt_i,
   input  logic [7:0]       status_i,
   input  logic [7:0]       core_rdata_i,
   output logic             ctl_we_o,
   output logic [7:0]       ctl_word_o,
   output logic             dat_we_o,
   output logic [7:0]       dat_o
);
   localparam logic [7:0] W_BUS   = 8'(1) << CW_BUS;
   localparam logic [7:0] W_INT   = 8'(1) << CW_INT;
   localparam logic [7:0] W_ACK   = 8'(1) << CW_ACK;
   localparam logic [7:0] W_START = 8'(1) << CW_START;
   localparam logic [7:0] W_STOP  = 8'(1) << CW_STOP;

   generate
      if (LEN_W < 2) begin : g_bad_len
         $error("i2c_msg_seq: LEN_W must be at least 2");
      end
      if (TMO_W < 2) begin : g_bad_tmo
         $error("i2c_msg_seq: TMO_W must be at least 2");
      end
   endgenerate

   phase_e           phase_q;
   logic [9:0]       addr_q;
   logic             ten_q, rd_q, rev_q;
   logic [LEN_W-1:0] left_q;
   logic             ack_q, sent_q, abort_q;
   logic             ten_eff;
   logic [7:0]       addr1, addr2;
   step_t            step;
   logic             take_start, take_evt, expire, ack_nx;

   assign busy_o     = (phase_q != PH_IDLE);
   assign take_start = start_i && !busy_o;
   assign take_evt   = evt_i && busy_o;
   assign ack_nx     = ack_q && !step.clr_ack;

   i2cseq_addr_fmt #(.TEN_EN(TEN_EN)) i_fmt (
      .addr_i(addr_q), .ten_i(ten_q), .rd_i(rd_q), .rev_i(rev_q),
      .ten_o(ten_eff), .first_o(addr1), .second_o(addr2));

   i2cseq_decide #(.LEN_W(LEN_W)) i_decide (
      .status_i(status_i), .ten_i(ten_eff), .left_i(left_q),
      .abort_i(abort_q), .sent_i(sent_q), .step_o(step));

   i2cseq_wdog #(.TMO_W(TMO_W)) i_wdog (
      .clk(clk), .rst_n(rst_n), .busy_i(busy_o),
      .restart_i(take_start || take_evt), .limit_i(tmo_limit_i),
      .expire_o(expire));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         addr_q <= '0; ten_q <= 1'b0; rd_q <= 1'b0; rev_q <= 1'b0;
         left_q <= '0; ack_q <= 1'b0; sent_q <= 1'b0; abort_q <= 1'b0;
         tx_take_o <= 1'b0; rx_valid_o <= 1'b0; rx_data_o <= '0;
         done_o <= 1'b0; result_o <= '0;
         ctl_we_o <= 1'b0; ctl_word_o <= '0; dat_we_o <= 1'b0; dat_o <= '0;
      end else begin
         tx_take_o  <= 1'b0;
         rx_valid_o <= 1'b0;
         done_o     <= 1'b0;
         ctl_we_o   <= 1'b0;
         dat_we_o   <= 1'b0;
         if (take_start) begin
            addr_q <= addr_i; ten_q <= ten_i; rd_q <= rd_i; rev_q <= rev_i;
            ack_q <= 1'b1; abort_q <= 1'b0;
            left_q <= len_i; sent_q <= 1'b0;
            ctl_we_o <= 1'b1;
            if (!nostart_i) begin
               ctl_word_o <= W_BUS | W_INT | W_ACK | W_START;
               phase_q    <= PH_START;
            end else if (rd_i) begin
               ctl_word_o <= W_BUS | W_INT | W_ACK;
               phase_q    <= PH_RXDATA;
            end else begin
               ctl_word_o <= W_BUS | W_INT | W_ACK;
               dat_we_o   <= 1'b1;
               dat_o      <= tx_data_i;
               tx_take_o  <= 1'b1;
               left_q     <= len_i - 1'b1;
               sent_q     <= 1'b1;
               phase_q    <= PH_TXACK;
            end
         end else if (evt_i && !busy_o) begin
            ctl_we_o   <= 1'b1;
            ctl_word_o <= W_BUS | W_STOP;
         end else if (take_evt) begin
            ack_q    <= ack_nx;
            ctl_we_o <= 1'b1;
            if (step.dec) left_q <= left_q - 1'b1;
            if (step.take) begin
               sent_q    <= 1'b1;
               tx_take_o <= 1'b1;
            end
            if (step.rx) begin
               rx_valid_o <= 1'b1;
               rx_data_o  <= core_rdata_i;
            end
            if (step.src != SRC_NONE) begin
               dat_we_o <= 1'b1;
               case (step.src)
                  SRC_ADDR1: dat_o <= addr1;
                  SRC_ADDR2: dat_o <= addr2;
                  default:   dat_o <= tx_data_i;
               endcase
            end
            if (step.stop) begin
               ctl_word_o <= W_BUS | W_STOP | (ack_nx ? W_ACK : 8'h00);
               done_o     <= 1'b1;
               result_o   <= ((step.res == RES_OK) && abort_q) ? RES_TIMEOUT : step.res;
               phase_q    <= PH_IDLE;
            end else begin
               ctl_word_o <= W_BUS | W_INT | (ack_nx ? W_ACK : 8'h00);
               phase_q    <= step.nxt;
            end
         end else if (expire) begin
            if (!abort_q) abort_q <= 1'b1;
            else begin
               phase_q  <= PH_IDLE;
               done_o   <= 1'b1;
               result_o <= RES_LOCKED;
            end
         end
      end
   end

   assert_done_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && result_o != 3'(RES_LOCKED)) |-> (ctl_we_o && ctl_word_o[CW_STOP] && !ctl_word_o[CW_INT]));
   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   assert_locked_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && result_o == 3'(RES_LOCKED)) |-> !ctl_we_o);
   assert_take_has_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take_o |-> dat_we_o);
   assert_rx_no_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |-> !dat_we_o);
   assert_start_stop_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we_o |-> !(ctl_word_o[CW_START] && ctl_word_o[CW_STOP]));
   assert_idle_evt_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && evt_i && !start_i) |=> (ctl_we_o && ctl_word_o == (W_BUS | W_STOP) && !done_o));
   assert_busy_start_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !evt_i) |=> !ctl_we_o);
endmodule

// File: tb/test_i2c_msg_seq.sv
module test_i2c_msg_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [9:0] addr_i = '0;
   logic ten_i = 1'b0, rd_i = 1'b0, rev_i = 1'b0, nostart_i = 1'b0;
   logic [7:0] len_i = '0;
   logic [15:0] tmo_limit_i = 16'd1000;
   logic [7:0] tx_data_i = '0;
   logic evt_i = 1'b0;
   logic [7:0] status_i = '0, core_rdata_i = '0;
   logic tx_take_o, rx_valid_o, busy_o, done_o, ctl_we_o, dat_we_o;
   logic [7:0] rx_data_o, ctl_word_o, dat_o;
   logic [2:0] result_o;

   int vectors = 0;
   int errors  = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   i2c_msg_seq i_i2c_msg_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .ten_i(ten_i),
      .rd_i(rd_i), .rev_i(rev_i), .nostart_i(nostart_i), .len_i(len_i),
      .tmo_limit_i(tmo_limit_i), .tx_data_i(tx_data_i), .tx_take_o(tx_take_o),
      .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o), .busy_o(busy_o), .done_o(done_o),
      .result_o(result_o), .evt_i(evt_i), .status_i(status_i), .core_rdata_i(core_rdata_i),
      .ctl_we_o(ctl_we_o), .ctl_word_o(ctl_word_o), .dat_we_o(dat_we_o), .dat_o(dat_o));

   task automatic cmp(string req, string what, int got, int exp);
      vectors++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
      end
   endtask

   task automatic expect_out(string req, bit cwe, logic [7:0] cw, bit dwe, logic [7:0] d,
                             bit tk, bit rxv, logic [7:0] rxd, bit dn, logic [2:0] res);
      cmp(req, "ctl_we", ctl_we_o, cwe);
      if (cwe) cmp(req, "ctl_word", ctl_word_o, cw);
      cmp(req, "dat_we", dat_we_o, dwe);
      if (dwe) cmp(req, "dat", dat_o, d);
      cmp(req, "tx_take", tx_take_o, tk);
      cmp(req, "rx_valid", rx_valid_o, rxv);
      if (rxv) cmp(req, "rx_data", rx_data_o, rxd);
      cmp(req, "done", done_o, dn);
      if (dn) cmp(req, "result", result_o, res);
   endtask

   function automatic logic [7:0] f_addr1(logic [9:0] a, bit ten, bit dir);
      return ten ? {5'b11110, a[9:8], dir} : {a[6:0], dir};
   endfunction

   task automatic go(logic [9:0] a, bit ten, bit rd, bit rev, bit ns, logic [7:0] len);
      addr_i = a; ten_i = ten; rd_i = rd; rev_i = rev; nostart_i = ns; len_i = len;
      start_i = 1'b1;
      @(posedge clk); @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic ev(logic [7:0] st, logic [7:0] rdata);
      status_i = st; core_rdata_i = rdata; evt_i = 1'b1;
      @(posedge clk); @(negedge clk);
      evt_i = 1'b0;
   endtask

   task automatic run_write(logic [9:0] a, bit ten, logic [7:0] len);
      logic [7:0] st;
      go(a, ten, 1'b0, 1'b0, 1'b0, len);
      expect_out("R3", 1, 8'h0F, 0, 0, 0, 0, 0, 0, 0);
      ev(8'h08, 0);
      expect_out(ten ? "R2" : "R1", 1, 8'h07, 1, f_addr1(a, ten, 1'b0), 0, 0, 0, 0, 0);
      st = 8'h18;
      if (ten) begin
         ev(8'h18, 0);
         expect_out("R2", 1, 8'h07, 1, a[7:0], 0, 0, 0, 0, 0);
         st = 8'hD0;
      end
      for (int i = 0; i < len; i++) begin
         tx_data_i = 8'($urandom);
         ev(st, 0);
         expect_out("R4", 1, 8'h07, 1, tx_data_i, 1, 0, 0, 0, 0);
         st = 8'h28;
      end
      ev(st, 0);
      expect_out(len == 0 ? "R6" : "R4", 1, 8'h15, 0, 0, 0, 0, 0, 1, 3'd0);
   endtask

   task automatic run_read(logic [9:0] a, bit ten, logic [7:0] len);
      logic [7:0] st, b;
      bit ack;
      go(a, ten, 1'b1, 1'b0, 1'b0, len);
      expect_out("R3", 1, 8'h0F, 0, 0, 0, 0, 0, 0, 0);
      ev(8'h10, 0);
      expect_out(ten ? "R2" : "R1", 1, 8'h07, 1, f_addr1(a, ten, 1'b1), 0, 0, 0, 0, 0);
      st = 8'h40;
      if (ten) begin
         ev(8'h40, 0);
         expect_out("R2", 1, 8'h07, 1, a[7:0], 0, 0, 0, 0, 0);
         st = 8'hE0;
      end
      ev(st, 0);
      if (len == 0) begin
         expect_out("R6", 1, 8'h15, 0, 0, 0, 0, 0, 1, 3'd0);
         return;
      end
      ack = (len != 1);
      expect_out("R5", 1, 8'h03 | (ack ? 8'h04 : 8'h00), 0, 0, 0, 0, 0, 0, 0);
      for (int k = 1; k < len; k++) begin
         b = 8'($urandom);
         ev(8'h50, b);
         if (len - k == 1) ack = 0;
         expect_out("R5", 1, 8'h03 | (ack ? 8'h04 : 8'h00), 0, 0, 0, 1, b, 0, 0);
      end
      b = 8'($urandom);
      ev(8'h58, b);
      expect_out("R5", 1, 8'h11, 0, 0, 0, 1, b, 1, 3'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      int n;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cmp("R8", "reset busy", busy_o, 0);
      cmp("R8", "reset done", done_o, 0);
      cmp("R3", "reset ctl_we", ctl_we_o, 0);

      // R1: reverse flag on a write gives dir 1; R7: address NACK
      go(10'h035, 0, 0, 1, 0, 8'd2);
      cmp("R3", "busy", busy_o, 1);
      ev(8'h08, 0);
      expect_out("R1", 1, 8'h07, 1, 8'h6B, 0, 0, 0, 0, 0);
      ev(8'h20, 0);
      expect_out("R7", 1, 8'h15, 0, 0, 0, 0, 0, 1, 3'd1);
      // R7: unexpected status
      go(10'h011, 0, 0, 0, 0, 8'd1);
      ev(8'h08, 0);
      ev(8'h38, 0);
      expect_out("R7", 1, 8'h15, 0, 0, 0, 0, 0, 1, 3'd2);
      // R10: event while idle
      ev(8'h08, 0);
      expect_out("R10", 1, 8'h11, 0, 0, 0, 0, 0, 0, 0);
      // R9: no-start write
      tx_data_i = 8'hA5;
      go(10'h022, 0, 0, 0, 1, 8'd2);
      expect_out("R9", 1, 8'h07, 1, 8'hA5, 1, 0, 0, 0, 0);
      tx_data_i = 8'h3C;
      ev(8'h28, 0);
      expect_out("R9", 1, 8'h07, 1, 8'h3C, 1, 0, 0, 0, 0);
      ev(8'h28, 0);
      expect_out("R9", 1, 8'h15, 0, 0, 0, 0, 0, 1, 3'd0);
      // R9: no-start read
      go(10'h022, 0, 1, 0, 1, 8'd2);
      expect_out("R9", 1, 8'h07, 0, 0, 0, 0, 0, 0, 0);
      ev(8'h50, 8'h91);
      expect_out("R9", 1, 8'h03, 0, 0, 0, 1, 8'h91, 0, 0);
      ev(8'h58, 8'h92);
      expect_out("R9", 1, 8'h11, 0, 0, 0, 1, 8'h92, 1, 3'd0);
      // R13: start while busy is ignored
      go(10'h055, 0, 0, 0, 0, 8'd1);
      ev(8'h08, 0);
      go(10'h3FF, 1, 1, 0, 0, 8'd9);
      expect_out("R13", 0, 0, 0, 0, 0, 0, 0, 0, 0);
      tx_data_i = 8'h77;
      ev(8'h18, 0);
      expect_out("R13", 1, 8'h07, 1, 8'h77, 1, 0, 0, 0, 0);
      ev(8'h28, 0);
      expect_out("R13", 1, 8'h15, 0, 0, 0, 0, 0, 1, 3'd0);
      // R11: write abort after one byte
      tmo_limit_i = 16'd20;
      go(10'h010, 0, 0, 0, 0, 8'd4);
      ev(8'h08, 0);
      tx_data_i = 8'h12;
      ev(8'h18, 0);
      n = 0;
      repeat (25) begin
         @(negedge clk);
         if (done_o || ctl_we_o) n++;
      end
      cmp("R11", "quiet during first timeout", n, 0);
      ev(8'h28, 0);
      expect_out("R11", 1, 8'h15, 0, 0, 0, 0, 0, 1, 3'd3);
      // R11: read abort clears ACK-enable at once
      go(10'h010, 0, 1, 0, 0, 8'd5);
      ev(8'h08, 0);
      ev(8'h40, 0);
      expect_out("R5", 1, 8'h07, 0, 0, 0, 0, 0, 0, 0);
      repeat (25) @(negedge clk);
      ev(8'h50, 8'h5A);
      expect_out("R11", 1, 8'h03, 0, 0, 0, 1, 8'h5A, 0, 0);
      ev(8'h58, 8'h5B);
      expect_out("R11", 1, 8'h11, 0, 0, 0, 1, 8'h5B, 1, 3'd3);
      // R12: locked bus after second timeout
      tmo_limit_i = 16'd10;
      go(10'h010, 0, 0, 0, 0, 8'd3);
      n = 0;
      while (!done_o && n < 100) begin
         @(posedge clk); @(negedge clk);
         n++;
      end
      cmp("R12", "cycles to lock", n, 22);
      expect_out("R12", 0, 0, 0, 0, 0, 0, 0, 1, 3'd4);
      cmp("R12", "busy after lock", busy_o, 0);
      ev(8'h28, 0);
      expect_out("R10", 1, 8'h11, 0, 0, 0, 0, 0, 0, 0);
      // random messages
      tmo_limit_i = 16'd1000;
      for (int m = 0; m < 60; m++) begin
         logic [9:0] a;
         bit ten;
         logic [7:0] len;
         a   = 10'($urandom);
         ten = 1'($urandom);
         len = 8'($urandom_range(0, 6));
         if ($urandom_range(0, 1) == 0) run_write(a, ten, len);
         else run_read(a, ten, len);
      end
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule